// File: doc/BRIEF.md
# Protected Serial-to-Parallel Sink Driver Controller

This block is the digital control core of an eight-channel protected sink driver. Data arrives one bit per shift-enabled clock on a serial input and moves through a shift register. The register's last stage is brought out so that several devices can be chained. A strobe copies the register into a bank of output latches, and each latch bit drives one channel request.

A combined enable/reset input forces every channel off while it is high. It also clears any channel that protection has shut down. Each channel has its own over-current flag. The flag is filtered by a counter of clock-enable ticks, so that short pulses are ignored. A qualified fault latches that channel off until the enable/reset input is raised or power-on reset is applied.

Two global flags, die over-temperature and supply under-voltage, hold every output off while either one is asserted. They leave the latches and the fault state untouched, so the channels resume from the latched pattern once both flags are released. The analog sensing is outside the block and appears here only as digital flags.

Top module: `prot_sipo_driver`

## Requirements
- R1: On a rising `clk` edge with `shift_en` high, the register shifts one place toward its top bit and takes `sdi` into bit 0. `sdo` always shows the top bit (bit CHANNELS-1), so after CHANNELS shifts the first bit shifted in appears on `sdo`. With `shift_en` low the register holds.
- R2: On a rising edge with `strobe` high, the output latches load the register contents present before that edge. Latch bit i drives `chan_out[i]`.
- R3: While `strobe` is low, shifting does not change `chan_out`.
- R4: While `en_rst` is high, every bit of `chan_out` is 0 with no clock delay. When it goes low, the latched pattern reappears.
- R5: A rising edge with `en_rst` high clears every channel fault and every filter count.
- R6: A channel's fault sets on the QUAL_TICKS-th rising edge at which both `tick` and that channel's `oc_flag` bit are high, provided the flag has stayed high in every cycle since counting began. From then on, that channel's output is 0.
- R7: If the over-current flag is low on any edge, the channel's count restarts from zero. Edges with `tick` low do not count.
- R8: A fault turns off only its own channel. The other channels keep following their latch bits.
- R9: While `thermal` is high all outputs are 0. When it is released, the outputs return to the latch pattern with existing faults still applied.
- R10: While `uvlo` is high all outputs are 0. It clears neither the latches nor the faults.
- R11: A set fault stays set after its over-current flag drops, until R5 or R12 clears it.
- R12: With `por_n` low, the shift register, latches, faults and counts are all cleared at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sdi | input | 1 | Serial data input |
| shift_en | input | 1 | Shift the register on this edge |
| sdo | output | 1 | Serial output, top register bit, for chaining |
| strobe | input | 1 | Copy the register into the output latches |
| en_rst | input | 1 | High: all outputs off and channel faults cleared |
| tick | input | 1 | Clock enable for the over-current filter |
| oc_flag | input | CHANNELS | Per-channel over-current flag |
| thermal | input | 1 | Over-temperature flag, forces all off |
| uvlo | input | 1 | Under-voltage flag, forces all off |
| chan_out | output | CHANNELS | Channel drive requests, 1 = sink on |

## Verification
Several properties are checked on every cycle. The global gate keeps all outputs at zero whenever enable/reset or either global flag is high. A faulted channel never drives. A fault is never dropped unless enable/reset is high. Enable/reset clears all faults on the next edge. A fault only appears after a ticked edge with its flag high. The latches stay put without a strobe.

Other behaviour can only be shown by the bench's scenarios. The sweep pushes all 256 byte patterns through shift and strobe and reads them back at the outputs. The serial output is checked across a cascade. The filter's exact tick count is tested, along with restarts after a dropout. The bench also shows that the global flags preserve the latched pattern and the faults, and that a mid-run power-on reset clears everything.

// File: rtl/prot_sipo_driver.sv
module prot_sipo_driver #(
  parameter int CHANNELS   = 8,
  parameter int QUAL_TICKS = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                sdi,
  input  logic                shift_en,
  output logic                sdo,
  input  logic                strobe,
  input  logic                en_rst,
  input  logic                tick,
  input  logic [CHANNELS-1:0] oc_flag,
  input  logic                thermal,
  input  logic                uvlo,
  output logic [CHANNELS-1:0] chan_out
);

  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

  logic [CHANNELS-1:0] shreg, latch_q, fault;
  logic                inhibit;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)        shreg <= '0;
    else if (shift_en) shreg <= {shreg[CHANNELS-2:0], sdi};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      latch_q <= '0;
    else if (strobe) latch_q <= shreg;

  assign sdo      = shreg[CHANNELS-1];
  assign inhibit  = en_rst | thermal | uvlo;
  assign chan_out = inhibit ? '0 : (latch_q & ~fault);

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n)
      if (!por_n) begin
        cnt      <= '0;
        fault[i] <= 1'b0;
      end else if (en_rst) begin
        cnt      <= '0;
        fault[i] <= 1'b0;
      end else if (!oc_flag[i]) begin
        cnt <= '0;
      end else if (tick && !fault[i]) begin
        if (cnt == LAST) fault[i] <= 1'b1;
        else             cnt      <= cnt + 1'b1;
      end

    p_fault_off_r8: assert property (@(posedge clk) disable iff (!por_n)
      fault[i] |-> !chan_out[i]);
    p_qual_r6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(fault[i]) |-> $past(oc_flag[i] && tick && !en_rst));
  end

  p_gate_r4: assert property (@(posedge clk) disable iff (!por_n)
    (en_rst || thermal || uvlo) |-> (chan_out == '0));
  p_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
    en_rst |=> (fault == '0));
  p_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
    !en_rst |=> ((fault & $past(fault)) == $past(fault)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    !strobe |=> $stable(latch_q));
  p_sdo_r1: assert property (@(posedge clk) disable iff (!por_n)
    shift_en |=> (sdo == $past(shreg[CHANNELS-2])));

endmodule

// File: tb/test_prot_sipo_driver.sv
module test_prot_sipo_driver;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int Q = 5;

  logic clk = 0, por_n = 0, sdi = 0, shift_en = 0, strobe = 0;
  logic en_rst = 1, tick = 0, thermal = 0, uvlo = 0, sdo;
  logic [N-1:0] oc_flag = '0, chan_out;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_sipo_driver #(.CHANNELS(N), .QUAL_TICKS(Q)) i_prot_sipo_driver (
    .clk, .por_n, .sdi, .shift_en, .sdo, .strobe, .en_rst, .tick,
    .oc_flag, .thermal, .uvlo, .chan_out);

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic shift_byte(logic [N-1:0] b);
    shift_en = 1;
    for (int k = N-1; k >= 0; k--) begin sdi = b[k]; step(); end
    shift_en = 0; sdi = 0;
  endtask

  task automatic load(logic [N-1:0] b);
    shift_byte(b);
    strobe = 1; step(); strobe = 0;
  endtask

  task automatic pulse_clear();
    en_rst = 1; step(); en_rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R12 reset outputs", chan_out, '0);
    chk("R12 reset sdo", {7'b0, sdo}, '0);
    por_n = 1; step();
    en_rst = 0;

    for (int b = 0; b < 256; b++) begin
      shift_byte(N'(b));
      chk("R1 sdo top bit", {7'b0, sdo}, {7'b0, b[7]});
      strobe = 1; step(); strobe = 0;
      chk("R2 latch sweep", chan_out, N'(b));
    end

    load(8'hA5);
    shift_en = 1; sdi = 0;
    for (int k = 7; k >= 0; k--) begin
      chk("R1 cascade sdo", {7'b0, sdo}, {7'b0, 8'hA5 >> k} & 8'h01);
      step();
    end
    shift_en = 0;
    chk("R3 no strobe holds", chan_out, 8'hA5);
    chk("R1 register cleared by zeros", {7'b0, sdo}, '0);
    shift_en = 0; step(); step();
    load(8'h3C);
    chk("R1 hold without shift_en", chan_out, 8'h3C);

    en_rst = 1; #1;
    chk("R4 enable off", chan_out, '0);
    en_rst = 0; #1;
    chk("R4 enable on", chan_out, 8'h3C);

    load(8'hFF);
    tick = 1;
    for (int i = 0; i < N; i++) begin
      oc_flag = N'(1) << i;
      repeat (Q-1) step();
      chk("R6 not yet qualified", chan_out, 8'hFF);
      step();
      chk("R6 R8 only own channel off", chan_out, ~(N'(1) << i));
      oc_flag = '0; step(); step();
      chk("R11 fault sticky", chan_out, ~(N'(1) << i));
      thermal = 1; #1;
      chk("R9 thermal all off", chan_out, '0);
      step(); thermal = 0; #1;
      chk("R9 thermal keeps fault", chan_out, ~(N'(1) << i));
      uvlo = 1; #1;
      chk("R10 uvlo all off", chan_out, '0);
      step(); uvlo = 0; #1;
      chk("R10 uvlo keeps fault", chan_out, ~(N'(1) << i));
      pulse_clear(); #1;
      chk("R5 clear restores", chan_out, 8'hFF);
    end

    oc_flag = 8'h81;
    repeat (Q-1) step();
    oc_flag = 8'h00; step();
    oc_flag = 8'h81;
    repeat (Q-1) step();
    chk("R7 dropout restarts count", chan_out, 8'hFF);
    step();
    chk("R6 two channels qualify", chan_out, 8'h7E);
    oc_flag = 0; pulse_clear(); #1;

    tick = 0; oc_flag = 8'hFF;
    repeat (3*Q) step();
    chk("R7 no tick no count", chan_out, 8'hFF);
    tick = 1;
    repeat (Q-1) step();
    oc_flag = 0; step();
    chk("R7 short pulse ignored", chan_out, 8'hFF);
    oc_flag = 8'h10;
    repeat (Q-1) step();
    en_rst = 1; step(); en_rst = 0;
    step();
    chk("R5 count cleared", chan_out, 8'hFF);
    oc_flag = 0;

    load(8'h5A);
    #(CLK_PERIOD/4) por_n = 0; #1;
    chk("R12 async reset", chan_out, '0);
    por_n = 1; step();
    chk("R12 latch cleared", chan_out, '0);
    chk("R12 register cleared", {7'b0, sdo}, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule